// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host end of a two-wire debug link. A controller hands it one register access at a time: whether the access goes to a debug-port or an access-port register, whether it reads or writes, a two-bit register address, and for writes a 32-bit word. The engine generates the serial clock, drives the shared data wire through an output value and an output-enable, and samples the wire when the target answers. At the end it pulses `done` and presents the target's acknowledge, the read word and a flag for bad read parity.

The engine also issues a line-reset command: a long run of high bits followed by a short run of low bits, used to bring the target's link state machine to a known point. The serial clock runs only while a command is in progress and sits low otherwise. Its period is a parameterised number of system clocks.

Top module: `swd_host_engine`

## Requirements
- R1: After reset and whenever idle, `busy`, `done` and `swclk` are 0, and the engine drives the data wire low (`swdio_oe` = 1, `swdio_o` = 0).
- R2: A transfer starts with 8 host-driven bits in this order: 1, port select (1 = access port), direction (1 = read), address bit 0, address bit 1, even parity over those four, 0, 1. Host output changes only while `swclk` is low. The host samples on the rising edge of `swclk`.
- R3: After the request there is one turnaround cycle with `swdio_oe` = 0. Then the target drives a 3-bit acknowledge, first bit into `ack[0]`. OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100.
- R4: A read with OK samples 32 data bits, least significant first, then one parity bit. A turnaround follows. The read takes 46 `swclk` cycles and returns the word on `rdata` with `done`.
- R5: A write with OK inserts one turnaround after the acknowledge. The host then drives 32 data bits, least significant first, and their even parity. The write takes 46 `swclk` cycles.
- R6: Any acknowledge other than 3'b001 skips the data phase. After one turnaround the engine finishes in 13 `swclk` cycles, reports the acknowledge and clears `par_err`.
- R7: On a read with OK, a parity bit that does not match the data sets `par_err`. The captured word is still returned. A matching bit clears `par_err`.
- R8: A line reset drives the wire high for RESET_HIGH cycles (default 50) and then low for RESET_IDLE cycles (default 2), with the output enabled throughout. It ends with `done`.
- R9: `swclk` has a period of 2×DIV system clocks. It is low when a command starts and stays low while idle.
- R10: `req_start` and `lr_start` pulses that arrive while `busy` is high are ignored.
- R11: If `lr_start` and `req_start` are seen in the same idle cycle, the line reset runs and the request is dropped.
- R12: `done` is a single-cycle pulse, and `busy` is already 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Pulse to start a register transfer |
| req_ap | input | 1 | 1 selects an access-port register, 0 a debug-port register |
| req_rnw | input | 1 | 1 for read, 0 for write |
| req_addr | input | 2 | Register address bits 3:2 |
| req_wdata | input | 32 | Write word |
| lr_start | input | 1 | Pulse to start a line reset |
| swclk | output | 1 | Serial debug clock |
| swdio_o | output | 1 | Value driven onto the data wire |
| swdio_oe | output | 1 | 1 when the host drives the data wire |
| swdio_i | input | 1 | Value sampled from the data wire |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| ack | output | 3 | Acknowledge of the last transfer |
| rdata | output | 32 | Word of the last successful read |
| par_err | output | 1 | Read parity mismatch on the last transfer |

## Verification
The assertions assume that the start pulses are synchronous to `clk`. They also assume that `swdio_i` only needs to be valid at rising `swclk` edges, so that nothing the target does can move the host's outputs while `swclk` is high. The bench meets this with a behavioural target. The target changes its bit only on falling `swclk` edges and presents a scripted value for each slot of the transfer. The bench drives start pulses on falling system-clock edges, so they are never sampled mid-change.

// File: rtl/swd_host_pkg.sv
`timescale 1ns/1ps
package swd_host_pkg;
  localparam int SWD_DW       = 32;
  localparam int SWD_REQ_BITS = 8;
  localparam int SWD_ACK_BITS = 3;

  localparam logic [SWD_ACK_BITS-1:0] SWD_ACK_OK    = 3'b001;
  localparam logic [SWD_ACK_BITS-1:0] SWD_ACK_WAIT  = 3'b010;
  localparam logic [SWD_ACK_BITS-1:0] SWD_ACK_FAULT = 3'b100;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_REQ,
    ST_TRN_A,
    ST_ACK,
    ST_RDAT,
    ST_TRN_W,
    ST_WDAT,
    ST_TRN_END,
    ST_LR_HI,
    ST_LR_LO
  } swd_state_e;

  typedef struct packed {
    logic              ap;
    logic              rnw;
    logic [1:0]        addr;
    logic [SWD_DW-1:0] wdata;
  } swd_req_t;
endpackage

// File: rtl/swd_clkgen.sv
`timescale 1ns/1ps
module swd_clkgen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic swclk,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          term;

  assign term     = run && (cnt_q == CW'(DIV - 1));
  assign rise_stb = term && !sck_q;
  assign fall_stb = term && sck_q;
  assign swclk    = sck_q;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end
endmodule

// File: rtl/swd_xor_par.sv
`timescale 1ns/1ps
module swd_xor_par #(
  parameter int W = 4
) (
  input  logic [W-1:0] bits,
  output logic         odd
);
  assign odd = ^bits;
endmodule

// File: rtl/swd_host_engine.sv
`timescale 1ns/1ps
module swd_host_engine
  import swd_host_pkg::*;
#(
  parameter int DIV        = 2,
  parameter int RESET_HIGH = 50,
  parameter int RESET_IDLE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_ap,
  input  logic        req_rnw,
  input  logic [1:0]  req_addr,
  input  logic [31:0] req_wdata,
  input  logic        lr_start,
  output logic        swclk,
  output logic        swdio_o,
  output logic        swdio_oe,
  input  logic        swdio_i,
  output logic        busy,
  output logic        done,
  output logic [2:0]  ack,
  output logic [31:0] rdata,
  output logic        par_err
);
  localparam int M1   = (RESET_HIGH > SWD_DW + 1) ? RESET_HIGH : SWD_DW + 1;
  localparam int MAXC = (RESET_IDLE > M1) ? RESET_IDLE : M1;
  localparam int IW   = $clog2(MAXC + 1);

  swd_state_e         st_q, st_d;
  logic [IW-1:0]      idx_q, idx_d;
  swd_req_t           req_q, req_d;
  logic [2:0]         asr_q, asr_d;
  logic [SWD_DW-1:0]  rsr_q, rsr_d;
  logic               rpar_q, rpar_d;
  logic [2:0]         ack_q, ack_d;
  logic [SWD_DW-1:0]  rdata_q, rdata_d;
  logic               perr_q, perr_d;
  logic               done_q, done_d;

  logic run, rise_stb, fall_stb;
  logic req_par, wr_par, rd_mismatch, ack_ok;
  logic [SWD_REQ_BITS-1:0] req_bits;

  assign run = (st_q != ST_IDLE);

  swd_clkgen #(.DIV(DIV)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .swclk    (swclk),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  swd_xor_par #(.W(4)) u_req_par (
    .bits ({req_q.addr, req_q.rnw, req_q.ap}),
    .odd  (req_par)
  );

  swd_xor_par #(.W(SWD_DW)) u_wr_par (
    .bits (req_q.wdata),
    .odd  (wr_par)
  );

  swd_xor_par #(.W(SWD_DW + 1)) u_rd_chk (
    .bits ({rpar_q, rsr_q}),
    .odd  (rd_mismatch)
  );

  assign ack_ok   = (asr_q == SWD_ACK_OK);
  // bit 0 goes out first
  assign req_bits = {1'b1, 1'b0, req_par, req_q.addr[1], req_q.addr[0],
                     req_q.rnw, req_q.ap, 1'b1};

  // next-state logic
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    req_d   = req_q;
    asr_d   = asr_q;
    rsr_d   = rsr_q;
    rpar_d  = rpar_q;
    ack_d   = ack_q;
    rdata_d = rdata_q;
    perr_d  = perr_q;
    done_d  = 1'b0;

    if (st_q == ST_IDLE) begin
      if (lr_start) begin
        st_d  = ST_LR_HI;
        idx_d = '0;
      end else if (req_start) begin
        st_d        = ST_REQ;
        idx_d       = '0;
        req_d.ap    = req_ap;
        req_d.rnw   = req_rnw;
        req_d.addr  = req_addr;
        req_d.wdata = req_wdata;
        asr_d       = '0;
      end
    end

    if (rise_stb) begin
      if (st_q == ST_ACK) begin
        asr_d = {swdio_i, asr_q[2:1]};
      end
      if (st_q == ST_RDAT) begin
        if (idx_q < IW'(SWD_DW)) begin
          rsr_d = {swdio_i, rsr_q[SWD_DW-1:1]};
        end else begin
          rpar_d = swdio_i;
        end
      end
    end

    if (fall_stb) begin
      idx_d = idx_q + IW'(1);
      case (st_q)
        ST_REQ: begin
          if (idx_q == IW'(SWD_REQ_BITS - 1)) begin
            st_d  = ST_TRN_A;
            idx_d = '0;
          end
        end
        ST_TRN_A: begin
          st_d  = ST_ACK;
          idx_d = '0;
        end
        ST_ACK: begin
          if (idx_q == IW'(SWD_ACK_BITS - 1)) begin
            idx_d = '0;
            if (!ack_ok)        st_d = ST_TRN_END;
            else if (req_q.rnw) st_d = ST_RDAT;
            else                st_d = ST_TRN_W;
          end
        end
        ST_RDAT: begin
          if (idx_q == IW'(SWD_DW)) begin
            st_d  = ST_TRN_END;
            idx_d = '0;
          end
        end
        ST_TRN_W: begin
          st_d  = ST_WDAT;
          idx_d = '0;
        end
        ST_WDAT: begin
          if (idx_q == IW'(SWD_DW)) begin
            st_d   = ST_IDLE;
            idx_d  = '0;
            done_d = 1'b1;
            ack_d  = asr_q;
            perr_d = 1'b0;
          end
        end
        ST_TRN_END: begin
          st_d   = ST_IDLE;
          idx_d  = '0;
          done_d = 1'b1;
          ack_d  = asr_q;
          if (req_q.rnw && ack_ok) begin
            rdata_d = rsr_q;
            perr_d  = rd_mismatch;
          end else begin
            perr_d = 1'b0;
          end
        end
        ST_LR_HI: begin
          if (idx_q == IW'(RESET_HIGH - 1)) begin
            st_d  = ST_LR_LO;
            idx_d = '0;
          end
        end
        ST_LR_LO: begin
          if (idx_q == IW'(RESET_IDLE - 1)) begin
            st_d   = ST_IDLE;
            idx_d  = '0;
            done_d = 1'b1;
          end
        end
        default: begin
          st_d  = ST_IDLE;
          idx_d = '0;
        end
      endcase
    end
  end

  // wire drive, changes only with state, i.e. on falling swclk
  always_comb begin
    swdio_oe = 1'b1;
    swdio_o  = 1'b0;
    case (st_q)
      ST_REQ:   swdio_o = req_bits[idx_q[2:0]];
      ST_WDAT:  swdio_o = (idx_q < IW'(SWD_DW)) ? req_q.wdata[idx_q[4:0]] : wr_par;
      ST_LR_HI: swdio_o = 1'b1;
      ST_TRN_A, ST_ACK, ST_RDAT, ST_TRN_W, ST_TRN_END: swdio_oe = 1'b0;
      default:  swdio_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      req_q   <= '0;
      asr_q   <= '0;
      rsr_q   <= '0;
      rpar_q  <= 1'b0;
      ack_q   <= '0;
      rdata_q <= '0;
      perr_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      req_q   <= req_d;
      asr_q   <= asr_d;
      rsr_q   <= rsr_d;
      rpar_q  <= rpar_d;
      ack_q   <= ack_d;
      rdata_q <= rdata_d;
      perr_q  <= perr_d;
      done_q  <= done_d;
    end
  end

  assign busy    = run;
  assign done    = done_q;
  assign ack     = ack_q;
  assign rdata   = rdata_q;
  assign par_err = perr_q;
endmodule

// File: rtl/swd_host_checks.sv
`timescale 1ns/1ps
module swd_host_checks (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic swclk,
  input logic swdio_o,
  input logic swdio_oe
);
  assert_idle_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (swdio_oe && !swdio_o));

  assert_swdio_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk && $past(swclk)) |-> ($stable(swdio_o) && $stable(swdio_oe)));

  assert_swclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !swclk);

  assert_start_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !swclk);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind swd_host_engine swd_host_checks u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .swclk    (swclk),
  .swdio_o  (swdio_o),
  .swdio_oe (swdio_oe)
);

// File: tb/swd_host_engine_tb.sv
`timescale 1ns/1ps
module swd_host_engine_tb;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic        req_ap = 1'b0;
  logic        req_rnw = 1'b0;
  logic [1:0]  req_addr = 2'b00;
  logic [31:0] req_wdata = 32'h0;
  logic        lr_start = 1'b0;
  logic        swclk, swdio_o, swdio_oe, swdio_i, busy, done, par_err;
  logic [2:0]  ack;
  logic [31:0] rdata;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural target
  logic tgt    [0:127];
  logic cap_o  [0:127];
  logic cap_oe [0:127];
  int nfall = 0, nrise = 0, base_f = 0, base_r = 0;
  int sys_cnt = 0, last_rise_cnt = 0, per_cyc = 0;
  int cur_f;

  always #2.5 clk = ~clk;

  swd_host_engine #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_ap(req_ap),
    .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
    .lr_start(lr_start), .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe),
    .swdio_i(swdio_i), .busy(busy), .done(done), .ack(ack), .rdata(rdata),
    .par_err(par_err)
  );

  assign cur_f   = nfall - base_f;
  assign swdio_i = (cur_f >= 0 && cur_f < 128) ? tgt[cur_f] : 1'b0;

  always @(posedge clk) sys_cnt = sys_cnt + 1;
  always @(negedge swclk) nfall = nfall + 1;
  always @(posedge swclk) begin
    int k;
    k = nrise - base_r;
    if (k >= 0 && k < 128) begin
      cap_o[k]  = swdio_o;
      cap_oe[k] = swdio_oe;
    end
    per_cyc       = sys_cnt - last_rise_cnt;
    last_rise_cnt = sys_cnt;
    nrise         = nrise + 1;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad = n_bad + 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_req(input logic ap, input logic rnw, input logic [1:0] a);
    return {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
  endfunction

  function automatic logic [7:0] got_req();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) v[i] = cap_o[i];
    return v;
  endfunction

  function automatic int rises();
    return nrise - base_r;
  endfunction

  task automatic script(input logic [2:0] tack, input logic [31:0] td, input logic flip);
    for (int i = 0; i < 128; i++) tgt[i] = 1'b0;
    for (int i = 0; i < 3; i++) tgt[9 + i] = tack[i];
    for (int i = 0; i < 32; i++) tgt[12 + i] = td[i];
    tgt[44] = (^td) ^ flip;
    base_f = nfall;
    base_r = nrise;
  endtask

  task automatic pulse_req(input logic ap, input logic rnw, input logic [1:0] a,
                           input logic [31:0] wd, input logic with_lr);
    @(negedge clk);
    req_ap = ap; req_rnw = rnw; req_addr = a; req_wdata = wd;
    req_start = 1'b1; lr_start = with_lr;
    @(negedge clk);
    req_start = 1'b0; lr_start = 1'b0;
  endtask

  task automatic wait_done(input string rq);
    int n;
    n = 0;
    while (done !== 1'b1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk({rq, " done seen"}, 64'(done), 64'(1));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 swclk", 64'(swclk), 0);
    chk("R1 drive", 64'({swdio_oe, swdio_o}), 64'(2'b10));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after release", 64'({busy, swclk, swdio_oe, swdio_o}), 64'(4'b0010));
  endtask

  task automatic t_read_ok(input logic ap, input logic [1:0] a, input logic [31:0] td);
    script(3'b001, td, 1'b0);
    pulse_req(ap, 1'b1, a, 32'h0, 1'b0);
    chk("R12 busy after start", 64'(busy), 1);
    wait_done("R4");
    chk("R2 request bits", 64'(got_req()), 64'(exp_req(ap, 1'b1, a)));
    chk("R3 turnaround released", 64'(cap_oe[8]), 0);
    chk("R3 ack released", 64'({cap_oe[9], cap_oe[10], cap_oe[11]}), 0);
    chk("R3 ack value", 64'(ack), 64'(3'b001));
    chk("R4 rdata", 64'(rdata), 64'(td));
    chk("R4 cycle count", 64'(rises()), 46);
    chk("R7 parity good", 64'(par_err), 0);
    chk("R9 swclk period", 64'(per_cyc), 64'(2 * DIV));
    chk("R12 busy low at done", 64'(busy), 0);
    @(negedge clk);
    chk("R12 done one cycle", 64'(done), 0);
  endtask

  task automatic t_read_badpar(input logic [31:0] td);
    script(3'b001, td, 1'b1);
    pulse_req(1'b1, 1'b1, 2'b11, 32'h0, 1'b0);
    wait_done("R7");
    chk("R7 parity error flagged", 64'(par_err), 1);
    chk("R7 word still returned", 64'(rdata), 64'(td));
  endtask

  task automatic t_write_ok(input logic ap, input logic [1:0] a, input logic [31:0] wd);
    logic [31:0] got;
    int oe_n;
    script(3'b001, 32'h0, 1'b0);
    pulse_req(ap, 1'b0, a, wd, 1'b0);
    wait_done("R5");
    chk("R2 request bits write", 64'(got_req()), 64'(exp_req(ap, 1'b0, a)));
    chk("R5 turnaround after ack", 64'({cap_oe[8], cap_oe[12]}), 0);
    oe_n = 0;
    for (int i = 0; i < 32; i++) got[i] = cap_o[13 + i];
    for (int i = 13; i <= 45; i++) oe_n += int'(cap_oe[i]);
    chk("R5 data bits", 64'(got), 64'(wd));
    chk("R5 data parity", 64'(cap_o[45]), 64'(^wd));
    chk("R5 host drives data", 64'(oe_n), 33);
    chk("R5 cycle count", 64'(rises()), 46);
    chk("R5 ack", 64'(ack), 64'(3'b001));
  endtask

  task automatic t_not_ok(input logic rnw, input logic [2:0] tack, input string rq);
    logic [31:0] prev;
    prev = rdata;
    script(tack, 32'hFFFF_FFFF, 1'b1);
    pulse_req(1'b0, rnw, 2'b10, 32'h1234_5678, 1'b0);
    wait_done(rq);
    chk({rq, " R6 ack reported"}, 64'(ack), 64'(tack));
    chk({rq, " R6 data skipped"}, 64'(rises()), 13);
    chk({rq, " R6 flag clear"}, 64'(par_err), 0);
    chk({rq, " R6 rdata untouched"}, 64'(rdata), 64'(prev));
    chk({rq, " R6 final turnaround"}, 64'(cap_oe[12]), 0);
  endtask

  task automatic t_line_reset(input logic with_req, input string rq);
    int hi, lo;
    script(3'b001, 32'h0, 1'b0);
    pulse_req(1'b1, 1'b1, 2'b01, 32'h0, 1'b1);
    if (!with_req) begin
      // pulse_req also raised req_start; this call covers R11
    end
    wait_done(rq);
    hi = 0;
    lo = 0;
    for (int i = 0; i < 50; i++) hi += int'(cap_o[i] && cap_oe[i]);
    for (int i = 50; i < 52; i++) lo += int'(!cap_o[i] && cap_oe[i]);
    chk({rq, " R8 high run"}, 64'(hi), 50);
    chk({rq, " R8 low run"}, 64'(lo), 2);
    chk({rq, " R8 R11 length"}, 64'(rises()), 52);
    repeat (4) @(negedge clk);
    chk({rq, " R11 request dropped"}, 64'(busy), 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] td;
    td = 32'h0BAD_F00D;
    script(3'b001, td, 1'b0);
    pulse_req(1'b0, 1'b1, 2'b01, 32'h0, 1'b0);
    repeat (20) @(negedge clk);
    pulse_req(1'b1, 1'b0, 2'b10, 32'hDEAD_0001, 1'b0);
    repeat (10) @(negedge clk);
    pulse_req(1'b1, 1'b0, 2'b11, 32'h0, 1'b1);
    wait_done("R10");
    chk("R10 original request kept", 64'(got_req()), 64'(exp_req(1'b0, 1'b1, 2'b01)));
    chk("R10 read completed", 64'(rdata), 64'(td));
    chk("R10 length unchanged", 64'(rises()), 46);
    repeat (5) @(negedge clk);
    chk("R10 no queued start", 64'(busy), 0);
  endtask

  initial begin
    t_reset();
    t_read_ok(1'b0, 2'b00, 32'h2BA0_1477);
    t_read_ok(1'b1, 2'b10, 32'h8000_0001);
    t_read_badpar(32'hFFFF_0000);
    t_read_ok(1'b0, 2'b01, 32'h1357_9BDF);
    t_write_ok(1'b1, 2'b01, 32'hA5C3_0F1E);
    t_write_ok(1'b0, 2'b11, 32'h0000_0001);
    t_not_ok(1'b0, 3'b010, "wait on write");
    t_not_ok(1'b1, 3'b100, "fault on read");
    t_not_ok(1'b1, 3'b111, "bad code");
    t_line_reset(1'b1, "line reset with request");
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule